// File: doc/BRIEF.md
# Float64 Range Select Unit

This block takes two IEEE-754 double-precision operands and a control byte. It returns one of the two operands, chosen as the smaller value, the larger value, the operand of smaller magnitude or the operand of larger magnitude. A two-bit field then sets the sign bit of the chosen operand. A typical use is clamping a value into a symmetric interval. The value goes in as the first operand and the bound as the second. Choosing the smaller magnitude while keeping the first operand's sign gives the clamped value.

The block handles the corner cases of floating-point selection in hardware:
- It quiets signaling NaNs and raises an invalid flag for them.
- A quiet NaN operand gives way to the other operand.
- Ties between opposite-signed zeros and between opposite-signed values of equal magnitude follow fixed rules.
- A denormal operand raises a flag, or is flushed to a signed zero when flushing is enabled.

All outputs are registered, so results appear one cycle after an accepted input.

Top module: `f64_range_sel`

## Requirements
- R1: `op_ctrl[1:0]` picks the compare. 00 gives the minimum and 01 the maximum. 10 gives the operand of smaller magnitude and 11 the operand of larger magnitude. On a tie under the ordinary compare, 00 and 10 pick `src_a`, and 01 and 11 pick `src_b`.
- R2: `op_ctrl[3:2]` sets result bit 63. 00 takes the sign of `src_a` and 01 keeps the sign of the chosen operand. 10 forces 0 and 11 forces 1. Bits 62:0 always come from the chosen operand.
- R3: A NaN is an operand with exponent bits 62:52 all ones and a nonzero fraction. It is quiet when bit 51 is 1 and signaling when bit 51 is 0. If `src_a` is signaling, the result is `src_a` with bit 51 set and `nan_invalid` is 1. Bits 63:52 and the other fraction bits are kept, and `op_ctrl[3:2]` has no effect.
- R4: If only `src_b` is signaling, the result is `src_b` with bit 51 set and `nan_invalid` is 1. `op_ctrl[3:2]` has no effect.
- R5: With no signaling NaN present, a quiet NaN in `src_b` selects `src_a`. Otherwise a quiet NaN in `src_a` selects `src_b`. `nan_invalid` stays 0 and `op_ctrl[3:2]` still applies.
- R6: Two zeros of opposite sign give -0 under compares 00 and 10, and +0 under compares 01 and 11, in either operand order.
- R7: Two nonzero operands of equal magnitude and opposite sign give the negative operand under compare 10 and the positive operand under compare 11, in either order.
- R8: A denormal operand has exponent 0 and a nonzero fraction. With `flush_den` at 0, it raises `den_seen`. The exceptions are when the other operand is a quiet NaN, or when either operand is a signaling NaN.
- R9: With `flush_den` at 1, a denormal operand is replaced by a zero of the same sign, both in the compare and in the result, and `den_seen` stays 0.
- R10: `bad_ctrl` is 1 exactly when `op_ctrl[7:4]` is nonzero. The result is still formed from `op_ctrl[3:0]`.
- R11: After reset all outputs are 0. A high `in_valid` updates all outputs one cycle later and raises `out_valid`. With `in_valid` low, `out_valid` is 0 and the other outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and control are presented this cycle |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| op_ctrl | input | 8 | Bits 1:0 compare, bits 3:2 sign, bits 7:4 must be zero |
| flush_den | input | 1 | Treat denormal operands as signed zeros |
| out_valid | output | 1 | Registered outputs belong to the last accepted input |
| result | output | 64 | Selected value |
| nan_invalid | output | 1 | A signaling NaN was seen |
| den_seen | output | 1 | A denormal operand was seen and not flushed |
| bad_ctrl | output | 1 | Reserved control bits were nonzero |

## Verification
The main function is exercised with operand pairs of distinct ordering:
- Ordinary positive and negative pairs separate the plain compare from the magnitude compare.
- Equal operands and equal magnitudes with opposite sign show whether ties pick the right side.
- Opposite-signed zeros in both orders separate the zero rule from the general tie rule.
- Every NaN pairing checks the priority order among signaling, quiet and ordinary operands, and whether the sign field is honoured or dropped.
- Denormals with flushing on and off separate flushing from flagging.

A long run of random pairs, drawn from those classes under all control values, is compared against a reference built on real-number comparison.

// File: rtl/f64_range_sel.sv
module f64_range_sel #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [EXP_W+FRAC_W:0]     src_a,
  input  logic [EXP_W+FRAC_W:0]     src_b,
  input  logic [7:0]                op_ctrl,
  input  logic                      flush_den,
  output logic                      out_valid,
  output logic [EXP_W+FRAC_W:0]     result,
  output logic                      nan_invalid,
  output logic                      den_seen,
  output logic                      bad_ctrl
);
  localparam int W   = EXP_W + FRAC_W + 1;
  localparam int MSB = W - 1;
  localparam int QB  = FRAC_W - 1;

  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  assign ea = src_a[MSB-1:FRAC_W];
  assign eb = src_b[MSB-1:FRAC_W];
  assign fa = src_a[FRAC_W-1:0];
  assign fb = src_b[FRAC_W-1:0];

  logic a_nan, b_nan, a_snan, b_snan, a_qnan, b_qnan, a_den, b_den;
  assign a_nan  = (&ea) && (|fa);
  assign b_nan  = (&eb) && (|fb);
  assign a_snan = a_nan && !fa[QB];
  assign b_snan = b_nan && !fb[QB];
  assign a_qnan = a_nan && fa[QB];
  assign b_qnan = b_nan && fb[QB];
  assign a_den  = (ea == '0) && (|fa);
  assign b_den  = (eb == '0) && (|fb);

  logic [W-1:0] xa, xb;
  assign xa = (flush_den && a_den) ? {src_a[MSB], {(W-1){1'b0}}} : src_a;
  assign xb = (flush_den && b_den) ? {src_b[MSB], {(W-1){1'b0}}} : src_b;

  logic [W-2:0] ma, mb;
  logic         sa, sb, a_zero, b_zero, mag_le, mag_eq, val_le;
  assign ma     = xa[W-2:0];
  assign mb     = xb[W-2:0];
  assign sa     = xa[MSB];
  assign sb     = xb[MSB];
  assign a_zero = (ma == '0);
  assign b_zero = (mb == '0);
  assign mag_le = (ma <= mb);
  assign mag_eq = (ma == mb);

  always_comb begin
    if (sa != sb)      val_le = sa;
    else if (!sa)      val_le = mag_le;
    else               val_le = (mb <= ma);
  end

  logic         any_snan;
  logic [W-1:0] pick, nxt_res;
  logic         nxt_den;
  assign any_snan = a_snan || b_snan;

  always_comb begin
    pick = xa;
    if (b_qnan)
      pick = xa;
    else if (a_qnan)
      pick = xb;
    else if (a_zero && b_zero && (sa != sb))
      pick = {!op_ctrl[0], {(W-1){1'b0}}};
    else if (mag_eq && (sa != sb) && op_ctrl[1])
      pick = op_ctrl[0] ? (sa ? xb : xa) : (sa ? xa : xb);
    else begin
      case (op_ctrl[1:0])
        2'b00:   pick = val_le ? xa : xb;
        2'b01:   pick = val_le ? xb : xa;
        2'b10:   pick = mag_le ? xa : xb;
        default: pick = mag_le ? xb : xa;
      endcase
    end
  end

  always_comb begin
    if (a_snan)
      nxt_res = src_a | (W'(1) << QB);
    else if (b_snan)
      nxt_res = src_b | (W'(1) << QB);
    else begin
      nxt_res = pick;
      case (op_ctrl[3:2])
        2'b00:   nxt_res[MSB] = src_a[MSB];
        2'b01:   nxt_res[MSB] = pick[MSB];
        2'b10:   nxt_res[MSB] = 1'b0;
        default: nxt_res[MSB] = 1'b1;
      endcase
    end
  end

  assign nxt_den = !flush_den && !any_snan &&
                   ((a_den && !b_qnan) || (b_den && !a_qnan));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      result      <= '0;
      nan_invalid <= 1'b0;
      den_seen    <= 1'b0;
      bad_ctrl    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result      <= nxt_res;
        nan_invalid <= any_snan;
        den_seen    <= nxt_den;
        bad_ctrl    <= |op_ctrl[7:4];
      end
    end
  end

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R11
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(nan_invalid));
  // R3
  quiet_on_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && any_snan |=> nan_invalid && (&result[MSB-1:FRAC_W]) && result[QB]);
  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(nan_invalid && den_seen));
  // R9
  flush_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && flush_den |=> !den_seen);
  // R10
  bad_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> bad_ctrl == ($past(op_ctrl[7:4]) != 4'd0));
  // R2
  sign_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !any_snan && op_ctrl[3:2] == 2'b10 |=> !result[MSB]);
  // R2
  sign_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !any_snan && op_ctrl[3:2] == 2'b11 |=> result[MSB]);
endmodule

// File: tb/f64_range_sel_tb.sv
module f64_range_sel_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [7:0] op_ctrl = '0;
  logic flush_den = 1'b0;
  logic out_valid, nan_invalid, den_seen, bad_ctrl;
  logic [63:0] result;

  always #5 clk = ~clk;

  f64_range_sel dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .op_ctrl(op_ctrl), .flush_den(flush_den), .out_valid(out_valid), .result(result),
    .nan_invalid(nan_invalid), .den_seen(den_seen), .bad_ctrl(bad_ctrl)
  );

  int vectors = 0;
  int errors  = 0;

  logic        e_v = 0, e_inv = 0, e_den = 0, e_bad = 0;
  logic [63:0] e_res = '0;
  string       e_tag = "R11";

  function automatic bit is_nan(logic [63:0] x); return (x[62:52] == 11'h7ff) && (x[51:0] != 0); endfunction
  function automatic bit is_sn(logic [63:0] x);  return is_nan(x) && !x[51]; endfunction
  function automatic bit is_qn(logic [63:0] x);  return is_nan(x) && x[51]; endfunction
  function automatic bit is_dn(logic [63:0] x);  return (x[62:52] == 0) && (x[51:0] != 0); endfunction
  function automatic real mag(logic [63:0] x);   return $bitstoreal({1'b0, x[62:0]}); endfunction

  task automatic model(input logic [63:0] a, b, input logic [7:0] c, input logic dz,
                       output logic [63:0] r, output logic inv, den, bad, output string tag);
    logic [63:0] fa, fb, t;
    real ra, rb;
    bad = (c[7:4] != 0);
    den = 0; inv = 0; tag = "R1";
    if (is_sn(a))      begin r = a; r[51] = 1; inv = 1; tag = "R3"; end
    else if (is_sn(b)) begin r = b; r[51] = 1; inv = 1; tag = "R4"; end
    else begin
      fa = (dz && is_dn(a)) ? {a[63], 63'd0} : a;
      fb = (dz && is_dn(b)) ? {b[63], 63'd0} : b;
      if (!dz) den = (is_dn(a) && !is_qn(b)) || (is_dn(b) && !is_qn(a));
      if (is_dn(a) || is_dn(b)) tag = dz ? "R9" : "R8";
      ra = $bitstoreal(fa); rb = $bitstoreal(fb);
      if (is_qn(b))      begin t = fa; tag = "R5"; end
      else if (is_qn(a)) begin t = fb; tag = "R5"; end
      else if (ra == 0.0 && rb == 0.0 && fa[63] != fb[63]) begin
        t = (c[0] == 0) ? 64'h8000_0000_0000_0000 : 64'h0; tag = "R6";
      end else if (c[1] && mag(fa) == mag(fb) && fa[63] != fb[63]) begin
        t = ((c[0] == 0) == fa[63]) ? fa : fb; tag = "R7";
      end else begin
        case (c[1:0])
          2'b00: t = (ra <= rb) ? fa : fb;
          2'b01: t = (ra <= rb) ? fb : fa;
          2'b10: t = (mag(fa) <= mag(fb)) ? fa : fb;
          default: t = (mag(fa) <= mag(fb)) ? fb : fa;
        endcase
      end
      r = t;
      case (c[3:2])
        2'b00: r[63] = a[63];
        2'b01: r[63] = t[63];
        2'b10: r[63] = 1'b0;
        default: r[63] = 1'b1;
      endcase
      if (c[3:2] != 2'b01 && tag == "R1") tag = "R2";
    end
    if (bad) tag = "R10";
  endtask

  always @(posedge clk or negedge rst_n) begin
    logic [63:0] r; logic i, d, b; string tg;
    if (!rst_n) begin
      e_v <= 0; e_res <= '0; e_inv <= 0; e_den <= 0; e_bad <= 0; e_tag <= "R11";
    end else begin
      e_v <= in_valid;
      if (in_valid) begin
        model(src_a, src_b, op_ctrl, flush_den, r, i, d, b, tg);
        e_res <= r; e_inv <= i; e_den <= d; e_bad <= b; e_tag <= tg;
      end else e_tag <= "R11";
    end
  end

  task automatic compare();
    vectors++;
    if ({out_valid, result, nan_invalid, den_seen, bad_ctrl} !== {e_v, e_res, e_inv, e_den, e_bad}) begin
      errors++;
      $display("FAIL %s: got v=%b r=%h i=%b d=%b b=%b expected v=%b r=%h i=%b d=%b b=%b",
               e_tag, out_valid, result, nan_invalid, den_seen, bad_ctrl,
               e_v, e_res, e_inv, e_den, e_bad);
    end
  endtask

  task automatic drive(input logic [63:0] a, b, input logic [7:0] c, input logic dz);
    in_valid = 1; src_a = a; src_b = b; op_ctrl = c; flush_den = dz;
    @(negedge clk); compare();
  endtask

  function automatic logic [63:0] pick_val(int k);
    logic [63:0] v;
    v = {$urandom, $urandom};
    case (k % 9)
      0: v[62:0] = '0;
      1: v[62:52] = '0;
      2: begin v[62:52] = 11'h7ff; v[51:0] = '0; end
      3: begin v[62:52] = 11'h7ff; v[51] = 1; end
      4: begin v[62:52] = 11'h7ff; v[51] = 0; v[0] = 1; end
      5: v = 64'h408F_F800_0000_0000 | {v[63], 63'd0};
      6: v[62:52] = 11'h400 + 11'($urandom_range(0, 3));
      default: ;
    endcase
    return v;
  endfunction

  localparam logic [63:0] P1 = 64'h3FF0_0000_0000_0000, N1 = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] P2 = 64'h4000_0000_0000_0000, N3 = 64'hC008_0000_0000_0000;
  localparam logic [63:0] PZ = 64'h0, NZ = 64'h8000_0000_0000_0000;
  localparam logic [63:0] SN = 64'h7FF0_0000_0000_0005, QN = 64'hFFF8_0000_0000_0007;
  localparam logic [63:0] DN = 64'h8000_0000_0000_0003, DP = 64'h0000_0000_0001_0000;

  initial begin
    #20000000;
    errors++;
    $display("FAIL R11: watchdog expired, got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();                                  // R11 reset state
    rst_n = 1;
    @(negedge clk); compare();                  // R11 idle after reset
    for (int c = 0; c < 4; c++) begin           // R1 ordinary pairs and ties
      drive(P1, P2, 8'(c), 0); drive(P2, P1, 8'(c), 0);
      drive(N3, P1, 8'(c), 0); drive(P1, N3, 8'(c), 0);
      drive(P2, P2, 8'(c | 4), 0);
    end
    for (int s = 0; s < 4; s++) drive(N3, P2, 8'(s << 2), 0);   // R2
    drive(SN, QN, 8'h0D, 0); drive(SN, DN, 8'h09, 0);           // R3
    drive(P1, SN, 8'h08, 0); drive(QN, SN, 8'h0C, 0);           // R4
    drive(QN, P1, 8'h00, 0); drive(N1, QN, 8'h0B, 0); drive(QN, QN, 8'h04, 0); // R5
    for (int c = 0; c < 4; c++) begin drive(PZ, NZ, 8'(c | 4), 0); drive(NZ, PZ, 8'(c | 4), 0); end // R6
    for (int c = 2; c < 4; c++) begin drive(P1, N1, 8'(c | 4), 0); drive(N1, P1, 8'(c | 4), 0); end // R7
    drive(DN, P1, 8'h04, 0); drive(DN, QN, 8'h04, 0); drive(P1, DP, 8'h05, 0); // R8
    drive(DN, PZ, 8'h04, 1); drive(DP, NZ, 8'h05, 1); drive(DP, P1, 8'h06, 1); // R9
    drive(P1, P2, 8'hA1, 0); drive(N3, P1, 8'h10, 0);          // R10
    in_valid = 0;
    repeat (2) begin @(negedge clk); compare(); end            // R11 hold
    for (int n = 0; n < 4000; n++) begin
      drive(pick_val($urandom), pick_val($urandom), 8'($urandom_range(0, 15)) |
            (($urandom_range(0, 15) == 0) ? 8'h40 : 8'h00), 1'($urandom));
      if ($urandom_range(0, 7) == 0) begin in_valid = 0; @(negedge clk); compare(); end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule